// File: doc/BRIEF.md
# Pseudo-static RAM pin timing monitor

This block sits passively on the pins between a bus master and an asynchronous pseudo-static RAM. It watches the pins with a fast sampling clock and never drives them. The memory refreshes its cells only while it is deselected, so the monitor mainly tracks how long the part stays selected without a break. It also checks the deselect gap between two selections, the hold-off after power-up, the width of each write window, the data setup before a write ends, and address stability inside a write.

Every timing limit is a parameter given in sampling-clock cycles. Each kind of violation sets its own sticky bit. A code records the first violation seen. Both are cleared only by an explicit clear input. A register holds the longest selected stretch seen so far, so traffic can be judged against the select-time limit even when it stays legal.

Top module: `psm_bus_monitor`

## Requirements
- R1: The device counts as selected only in a cycle where `cs_n_i` is 0 and `cs2_i` is 1. Every other combination counts as deselected and can raise none of the select-based errors.
- R2: When a selected cycle is preceded by `SEL_MAX_CYC` or more consecutive selected cycles, bit 0 of `err_o` sets after that clock edge. A run of exactly `SEL_MAX_CYC` selected cycles raises nothing. Reads and writes both count toward the run.
- R3: When the device is reselected after a deselect run of at least one cycle but fewer than `GAP_MIN_CYC` cycles, bit 1 sets.
- R4: A selected cycle that falls within the first `PWRUP_CYC` cycles after reset release sets bit 2. Selection after that window does not set it.
- R5: The write window is a selected cycle with `we_n_i` at 0 and at least one of `ub_n_i` or `lb_n_i` at 0. When a window lasts fewer than `WR_MIN_CYC` cycles, bit 3 sets on the cycle after it closes.
- R6: When a window closes, `data_i` must have held the same value for at least `SETUP_MIN_CYC` cycles, counted back from the last window cycle. Otherwise bit 4 sets.
- R7: When `addr_i` changes between two consecutive cycles of the same write window, bit 5 sets.
- R8: Error bits are sticky. Only a cycle with `clr_i` at 1 clears them. A clear takes priority over violations in the same cycle, and it also zeroes `err_code_o` and `max_sel_o`.
- R9: `err_code_o` is 0 while no error is latched. Otherwise it holds the bit index plus one of the first violation after the last clear. When several violations occur in the same cycle, the lowest index wins.
- R10: `max_sel_o` holds the longest run of consecutive selected cycles since reset or clear, including the current run. It saturates at `SEL_MAX_CYC+1`.
- R11: With `we_n_i` at 0 but both byte selects at 1, no write window exists, so bits 3, 4 and 5 stay clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | sampling clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| clr_i | input | 1 | clears the error bits, the error code and the longest-stretch register |
| cs_n_i | input | 1 | active-low chip select seen on the bus |
| cs2_i | input | 1 | active-high chip select seen on the bus |
| we_n_i | input | 1 | active-low write enable seen on the bus |
| ub_n_i | input | 1 | active-low upper byte select |
| lb_n_i | input | 1 | active-low lower byte select |
| addr_i | input | AW | address seen on the bus |
| data_i | input | DW | data seen on the bus |
| err_o | output | 6 | sticky violation bits, indexed as in R2 to R7 |
| err_code_o | output | 3 | first violation code (R9) |
| max_sel_o | output | $clog2(SEL_MAX_CYC+2) | longest selected stretch in cycles |

## Verification
Each run counter would show a fault as an error bit that sets one run length early or late. A boundary test of one cycle either side of each limit exposes this on the clock edge right after the offending cycle. A bad priority or stickiness fault shows up in `err_code_o` or in a bit that drops without a clear, and it is visible from then until the next clear. A wrong select decode makes `max_sel_o` grow during cycles the bus does not select, so the fault shows within one cycle. The bench runs a cycle-level reference model beside the directed cases and a seeded random traffic phase, and compares all three outputs on every cycle.

// File: rtl/psm_mon_pkg.sv
package psm_mon_pkg;
    localparam int NUM_ERR = 6;
    localparam int CODE_W  = 3;

    localparam int ERR_SEL_LONG = 0;
    localparam int ERR_GAP      = 1;
    localparam int ERR_PWRUP    = 2;
    localparam int ERR_WR_SHORT = 3;
    localparam int ERR_SETUP    = 4;
    localparam int ERR_ADDR     = 5;

    typedef logic [NUM_ERR-1:0] err_vec_t;
endpackage

// File: rtl/psm_run_cnt.sv
// Saturating run-length counter: counts while run_i is high, reloads otherwise.
module psm_run_cnt #(
    parameter int LIMIT    = 1,
    parameter int RST_VAL  = 0,
    parameter int LOAD_VAL = 0
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         run_i,
    output logic [$clog2(LIMIT+1)-1:0]   cnt_o
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM_V  = W'(LIMIT);
    localparam logic [W-1:0] RST_V  = W'(RST_VAL);
    localparam logic [W-1:0] LOAD_V = W'(LOAD_VAL);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run_i) begin
            if (st_q.cnt != LIM_V) st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = LOAD_V;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{cnt: RST_V};
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/psm_err_latch.sv
// Sticky violation bits plus first-violation code.
module psm_err_latch
    import psm_mon_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  err_vec_t          viol_i,
    output err_vec_t          err_o,
    output logic [CODE_W-1:0] code_o
);
    typedef struct packed {
        err_vec_t          err;
        logic [CODE_W-1:0] code;
    } latch_st_t;

    latch_st_t st_d, st_q;
    logic [CODE_W-1:0] first_code;

    always_comb begin
        first_code = '0;
        for (int i = NUM_ERR - 1; i >= 0; i--) begin
            if (viol_i[i]) first_code = CODE_W'(i + 1);
        end
    end

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else begin
            st_d.err = st_q.err | viol_i;
            if (st_q.code == '0) st_d.code = first_code;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign err_o  = st_q.err;
    assign code_o = st_q.code;

    // R9
    code_tracks_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.err != '0) == (st_q.code != '0));

    // R8
    sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> ((st_q.err & $past(st_q.err)) == $past(st_q.err)));

    // R8
    clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (st_q.err == '0 && st_q.code == '0));
endmodule

// File: rtl/psm_bus_monitor.sv
module psm_bus_monitor
    import psm_mon_pkg::*;
#(
    parameter int AW            = 19,
    parameter int DW            = 16,
    parameter int SEL_MAX_CYC   = 3000,
    parameter int GAP_MIN_CYC   = 1,
    parameter int PWRUP_CYC     = 10000,
    parameter int WR_MIN_CYC    = 9,
    parameter int SETUP_MIN_CYC = 5
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             clr_i,
    input  logic                             cs_n_i,
    input  logic                             cs2_i,
    input  logic                             we_n_i,
    input  logic                             ub_n_i,
    input  logic                             lb_n_i,
    input  logic [AW-1:0]                    addr_i,
    input  logic [DW-1:0]                    data_i,
    output logic [NUM_ERR-1:0]               err_o,
    output logic [CODE_W-1:0]                err_code_o,
    output logic [$clog2(SEL_MAX_CYC+2)-1:0] max_sel_o
);
    localparam int SELW = $clog2(SEL_MAX_CYC + 2);
    localparam int GAPW = $clog2(GAP_MIN_CYC + 1);
    localparam int PWRW = $clog2(PWRUP_CYC + 1);
    localparam int WRW  = $clog2(WR_MIN_CYC + 1);
    localparam int STW  = $clog2(SETUP_MIN_CYC + 1);
    localparam logic [SELW-1:0] SEL_MAX_V = SELW'(SEL_MAX_CYC);
    localparam logic [SELW-1:0] SEL_LIM_V = SELW'(SEL_MAX_CYC + 1);
    localparam logic [GAPW-1:0] GAP_V     = GAPW'(GAP_MIN_CYC);
    localparam logic [PWRW-1:0] PWR_V     = PWRW'(PWRUP_CYC);
    localparam logic [WRW-1:0]  WR_V      = WRW'(WR_MIN_CYC);
    localparam logic [STW-1:0]  ST_V      = STW'(SETUP_MIN_CYC);

    typedef struct packed {
        logic [AW-1:0]   addr;
        logic [DW-1:0]   data;
        logic [SELW-1:0] maxs;
    } mon_st_t;

    mon_st_t st_d, st_q;

    logic            sel, win, data_same;
    logic [SELW-1:0] sel_cnt, sel_cur;
    logic [GAPW-1:0] gap_cnt;
    logic [PWRW-1:0] pwr_cnt;
    logic [WRW-1:0]  wr_cnt;
    logic [STW-1:0]  st_cnt;
    err_vec_t        viol;

    assign sel       = !cs_n_i && cs2_i;
    assign win       = sel && !we_n_i && (!ub_n_i || !lb_n_i);
    assign data_same = (data_i == st_q.data);

    psm_run_cnt #(.LIMIT(SEL_MAX_CYC + 1), .RST_VAL(0), .LOAD_VAL(0)) sel_run_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .run_i(sel), .cnt_o(sel_cnt));
    psm_run_cnt #(.LIMIT(GAP_MIN_CYC), .RST_VAL(GAP_MIN_CYC), .LOAD_VAL(0)) gap_run_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .run_i(!sel), .cnt_o(gap_cnt));
    psm_run_cnt #(.LIMIT(PWRUP_CYC), .RST_VAL(0), .LOAD_VAL(0)) pwr_run_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .run_i(1'b1), .cnt_o(pwr_cnt));
    psm_run_cnt #(.LIMIT(WR_MIN_CYC), .RST_VAL(0), .LOAD_VAL(0)) wr_run_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .run_i(win), .cnt_o(wr_cnt));
    psm_run_cnt #(.LIMIT(SETUP_MIN_CYC), .RST_VAL(0), .LOAD_VAL(1)) st_run_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .run_i(data_same), .cnt_o(st_cnt));

    always_comb begin
        st_d      = st_q;
        st_d.addr = addr_i;
        st_d.data = data_i;

        viol                = '0;
        viol[ERR_SEL_LONG]  = sel && (sel_cnt >= SEL_MAX_V);
        viol[ERR_GAP]       = sel && (gap_cnt != '0) && (gap_cnt < GAP_V);
        viol[ERR_PWRUP]     = sel && (pwr_cnt < PWR_V);
        viol[ERR_WR_SHORT]  = !win && (wr_cnt != '0) && (wr_cnt < WR_V);
        viol[ERR_SETUP]     = !win && (wr_cnt != '0) && (st_cnt < ST_V);
        viol[ERR_ADDR]      = win && (wr_cnt != '0) && (addr_i != st_q.addr);

        if (!sel)                  sel_cur = '0;
        else if (sel_cnt == SEL_LIM_V) sel_cur = SEL_LIM_V;
        else                       sel_cur = sel_cnt + 1'b1;

        if (clr_i)                   st_d.maxs = '0;
        else if (sel_cur > st_q.maxs) st_d.maxs = sel_cur;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    psm_err_latch err_latch_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
        .viol_i(viol), .err_o(err_o), .code_o(err_code_o));

    assign max_sel_o = st_q.maxs;

    // R2
    sel_long_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_o[ERR_SEL_LONG]) |-> ($past(sel_cnt) >= SEL_MAX_V));

    // R10
    max_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> (max_sel_o >= $past(max_sel_o)));

    // R10
    max_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        max_sel_o <= SEL_LIM_V);

    // R1
    desel_no_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel |=> (sel_cnt == '0));
endmodule

// File: tb/psm_bus_monitor_tb_top.sv
module psm_bus_monitor_tb_top;
    localparam int AW = 19, DW = 16;
    localparam int SELM = 40, GAPM = 2, PWRM = 30, WRM = 6, SUM = 3;
    localparam int SELW = $clog2(SELM + 2);
    localparam int WDOG = 150000;

    logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
    logic cs_n = 1'b1, cs2 = 1'b0, we_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic [5:0] err;
    logic [2:0] code;
    logic [SELW-1:0] maxs;

    int checks = 0, fails = 0, cycles = 0;
    // reference model state
    int m_selrun, m_gap, m_age, m_wr, m_stab, m_max, m_code;
    int m_err;
    logic [AW-1:0] m_aprev;
    logic [DW-1:0] m_dprev;

    always #2.5 clk = ~clk;

    psm_bus_monitor #(.AW(AW), .DW(DW), .SEL_MAX_CYC(SELM), .GAP_MIN_CYC(GAPM),
        .PWRUP_CYC(PWRM), .WR_MIN_CYC(WRM), .SETUP_MIN_CYC(SUM)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .cs_n_i(cs_n), .cs2_i(cs2),
        .we_n_i(we_n), .ub_n_i(ub_n), .lb_n_i(lb_n), .addr_i(addr), .data_i(data),
        .err_o(err), .err_code_o(code), .max_sel_o(maxs));

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WDOG);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lowest_code(input int v);
        for (int i = 0; i < 6; i++) if (v[i]) return i + 1;
        return 0;
    endfunction

    // expected violations for the cycle described by the current inputs
    function automatic int model_viol();
        int v = 0;
        logic s, w;
        s = !cs_n && cs2;
        w = s && !we_n && (!ub_n || !lb_n);
        if (s && m_selrun >= SELM)               v |= 1;
        if (s && m_gap > 0 && m_gap < GAPM)      v |= 2;
        if (s && m_age < PWRM)                   v |= 4;
        if (!w && m_wr > 0 && m_wr < WRM)        v |= 8;
        if (!w && m_wr > 0 && m_stab < SUM)      v |= 16;
        if (w && m_wr > 0 && addr != m_aprev)    v |= 32;
        return v;
    endfunction

    task automatic model_step();
        int v;
        logic s, w;
        v = model_viol();
        s = !cs_n && cs2;
        w = s && !we_n && (!ub_n || !lb_n);
        m_selrun = s ? m_selrun + 1 : 0;
        m_gap    = s ? 0 : m_gap + 1;
        m_age++;
        m_wr     = w ? m_wr + 1 : 0;
        m_stab   = (data == m_dprev) ? m_stab + 1 : 1;
        m_dprev  = data;
        m_aprev  = addr;
        if (clr) begin
            m_err = 0; m_code = 0; m_max = 0;
        end else begin
            m_err |= v;
            if (m_code == 0) m_code = lowest_code(v);
            if (((m_selrun > SELM + 1) ? SELM + 1 : m_selrun) > m_max)
                m_max = (m_selrun > SELM + 1) ? SELM + 1 : m_selrun;
        end
    endtask

    // one sampling cycle with the currently driven inputs; compares after the edge
    task automatic cyc();
        model_step();
        @(posedge clk); #1;
        chk("R8 model err", int'(err), m_err);
        chk("R9 model code", int'(code), m_code);
        chk("R10 model max", int'(maxs), m_max);
        clr = 1'b0;
    endtask

    task automatic drive(input logic c_n, input logic c2, input logic w_n,
                         input logic u_n, input logic l_n, input int n);
        cs_n = c_n; cs2 = c2; we_n = w_n; ub_n = u_n; lb_n = l_n;
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic idle(input int n);  drive(1, 0, 1, 1, 1, n); endtask
    task automatic rd(input int n);    drive(0, 1, 1, 0, 0, n); endtask
    task automatic clear();  clr = 1'b1; idle(1); endtask

    // write window of len cycles; data holds its final value for the last hold cycles
    task automatic wr(input int len, input int hold, input bit addr_jump);
        data = 16'h1111; rd(1);
        for (int i = 0; i < len; i++) begin
            data = (i >= len - hold) ? 16'h3c3c : 16'h5a5a;
            if (addr_jump && i == len / 2) addr = addr + 1'b1;
            drive(0, 1, 0, 1, 0, 1);
        end
        rd(1);
        idle(3);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cs_n = 1; cs2 = 0; we_n = 1; ub_n = 1; lb_n = 1; clr = 0;
        addr = '0; data = '0;
        repeat (3) @(posedge clk);
        #1;
        m_selrun = 0; m_gap = GAPM; m_age = 0; m_wr = 0; m_stab = 0;
        m_max = 0; m_code = 0; m_err = 0; m_aprev = '0; m_dprev = '0;
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #1;
        do_reset();
        chk("R8 reset err", int'(err), 0);
        chk("R9 reset code", int'(code), 0);
        chk("R10 reset max", int'(maxs), 0);

        // R4: selection inside the power-up window
        idle(2); rd(1);
        chk("R4 early select", int'(err[2]), 1);
        chk("R9 code for power-up", int'(code), 3);
        idle(3);
        chk("R8 sticky", int'(err[2]), 1);
        clear();
        chk("R8 clear", int'(err), 0);
        idle(PWRM + 2); rd(5); idle(3);
        chk("R4 late select", int'(err[2]), 0);

        // R1: non-selecting combinations
        drive(0, 0, 0, 0, 0, SELM + 20);
        drive(1, 1, 0, 0, 0, SELM + 20);
        chk("R1 decode err", int'(err), 0);
        chk("R1 decode max", int'(maxs), 5);

        // R2 / R10
        clear(); idle(3); rd(SELM); idle(3);
        chk("R2 exact limit", int'(err[0]), 0);
        chk("R10 max at limit", int'(maxs), SELM);
        rd(SELM + 1); idle(3);
        chk("R2 over limit", int'(err[0]), 1);
        chk("R9 code select", int'(code), 1);
        rd(SELM + 10); idle(3);
        chk("R10 saturate", int'(maxs), SELM + 1);

        // R3
        clear(); idle(3); rd(3); idle(1); rd(3); idle(3);
        chk("R3 short gap", int'(err[1]), 1);
        clear(); rd(3); idle(GAPM); rd(3); idle(3);
        chk("R3 legal gap", int'(err[1]), 0);

        // R5 / R6
        clear(); wr(WRM, SUM, 0);
        chk("R5 legal pulse", int'(err), 0);
        wr(WRM - 1, SUM, 0);
        chk("R5 short pulse", int'(err[3]), 1);
        chk("R6 setup ok", int'(err[4]), 0);
        clear(); wr(8, SUM - 1, 0);
        chk("R6 short setup", int'(err[4]), 1);
        chk("R5 long pulse", int'(err[3]), 0);
        clear(); wr(8, SUM, 0);
        chk("R6 setup met", int'(err), 0);

        // R11: write enable without byte selects
        drive(0, 1, 0, 1, 1, 2); idle(3);
        chk("R11 no byte select", int'(err), 0);

        // R7
        wr(8, 3, 1);
        chk("R7 address moved", int'(err[5]), 1);

        // R9: simultaneous violations pick the lowest index
        clear(); wr(4, 1, 0);
        chk("R9 simultaneous bits", int'(err), 24);
        chk("R9 simultaneous code", int'(code), 4);
        // R9: first violation is kept
        clear(); rd(2); idle(1); rd(SELM + 2); idle(3);
        chk("R9 first kept", int'(code), 2);
        chk("R2 later bit", int'(err[0]), 1);
        clear();

        // random traffic checked against the model every cycle
        for (int seg = 0; seg < 700; seg++) begin
            int kind = $urandom % 5;
            int len = 1 + ($urandom % 12);
            if (($urandom % 40) == 0) clr = 1'b1;
            for (int i = 0; i < len + ((kind == 4) ? 30 : 0); i++) begin
                if (($urandom % 4) == 0) data = DW'($urandom);
                if (($urandom % 9) == 0) addr = AW'($urandom);
                case (kind)
                    0: drive(1, 0, 1, 1, 1, 1);
                    1: drive(0, 1, 1, 0, 0, 1);
                    2: drive(0, 1, 0, 1'($urandom), 1'($urandom), 1);
                    3: drive(1'($urandom), 1'($urandom), 1'($urandom), 0, 1, 1);
                    default: drive(0, 1, 1, 1, 0, 1);
                endcase
            end
        end

        summary();
        $finish;
    end
endmodule